// File: doc/BRIEF.md
# Two-Phase Bus Cycle Controller and Memory Decoder

This block runs the bus cycles of a small 16-bit, word-addressed machine. Its memory map holds 2048 words of read-only storage at the bottom and 2048 words of read-write storage directly above it. Each region is two byte-wide chips placed side by side to form a 16-bit word. The fast system clock is slowed by a divide-by-three clock enable. One period of that enable is one bus clock. Every bus transfer lasts two bus clocks. The first bus clock carries only the address. The second bus clock carries the data, together with the strobes and chip selects.

A requester holds `req_valid` with a cycle kind and a word address until `req_accept` pulses. The block then latches both values and drives the low eleven address bits to every chip for the whole transfer. It decodes all upper address bits, so each location has exactly one address. Any address outside the two regions, or any write aimed at the read-only region, selects no chip and fires no data strobe. Instead it raises an error flag for the data phase. The block also tells the requester when it owns the shared data bus.

Top module: `wbus_ctrl`

## Requirements
- R1: `clk_en` is high for exactly one clock out of every three. Its first pulse comes in the third clock after reset is released.
- R2: `req_accept` is high only when `clk_en` and `req_valid` are both high and no address phase is running. The kind and address present in that clock are the ones latched.
- R3: After an accept, `addr_phase` is high for one full enable period. `data_phase` is then high for the next period. If a new request is accepted at the end of a data phase, an address phase follows directly. Otherwise both phase outputs are low.
- R4: During both phases, `bus_addr` carries bits 10:0 of the latched address and does not change. It is zero when the bus is idle.
- R5: A memory read at word address 0 to 2047 drives both bits of `rom_cs_n` low during the data phase, and only then.
- R6: A memory read or write at word address 2048 to 4095 drives both bits of `ram_cs_n` low during the data phase, and only then.
- R7: A memory cycle at an address above 4095 selects no chip and raises no read or write strobe. It sets `dec_err` for its data phase.
- R8: A memory write to address 0 to 2047 selects no chip and does not raise `mem_wr`. It sets `dec_err` for its data phase.
- R9: Kind encoding: 00 is memory read, 01 is memory write, 10 is I/O read, 11 is I/O write. During the data phase, `mem_req` or `io_req` marks the space being accessed. The matching read or write strobe is also raised, except in the error cases of R7 and R8. No strobe is active outside a data phase.
- R10: `cpu_drive` is high only in the data phase of a write that is not rejected. It is never high together with a read strobe.
- R11: While reset is held, all chip selects are high, all strobes, phases, flags and `cpu_drive` are low, and `bus_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until accepted |
| req_kind | input | 2 | Cycle kind (see R9) |
| req_addr | input | 16 | Word address |
| req_accept | output | 1 | Request latched this clock |
| clk_en | output | 1 | Bus clock enable, one clock in three |
| addr_phase | output | 1 | First bus clock of a transfer |
| data_phase | output | 1 | Second bus clock of a transfer |
| bus_addr | output | 11 | In-chip word address to all chips |
| rom_cs_n | output | 2 | Active-low selects, read-only chip pair |
| ram_cs_n | output | 2 | Active-low selects, read-write chip pair |
| mem_req | output | 1 | Memory transfer in data phase |
| io_req | output | 1 | I/O transfer in data phase |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| dec_err | output | 1 | Rejected memory access in data phase |
| cpu_drive | output | 1 | Requester owns the data bus |

## Verification
The assertions assume that a requester keeps `req_kind` and `req_addr` steady while `req_valid` is high. They also assume that reset is the only way a transfer is cut short. The stimulus follows both rules. It changes request inputs only on the falling edge after an accept, and it leaves `req_valid` low whenever reset is applied in the middle of a transfer. Under these rules the properties only need to relate enable pulses, phases, selects and strobes. They never depend on which request arrived when.

// File: rtl/wbus_pkg.sv
package wbus_pkg;

  // Cycle kind: bit 1 picks the I/O space, bit 0 marks a write.
  typedef enum logic [1:0] {
    KIND_MRD = 2'b00,
    KIND_MWR = 2'b01,
    KIND_IRD = 2'b10,
    KIND_IWR = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10
  } phase_e;

  function automatic logic kind_is_io(kind_e k);
    return k[1];
  endfunction

  function automatic logic kind_is_wr(kind_e k);
    return k[0];
  endfunction

endpackage

// File: rtl/wbus_clk_div.sv
module wbus_clk_div #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wbus_cycle_fsm.sv
module wbus_cycle_fsm
  import wbus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  kind_e             req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              accept,
  output phase_e            phase,
  output kind_e             lat_kind,
  output logic [ADDR_W-1:0] lat_addr
);
  phase_e ph_q, ph_d;
  logic   can_take;

  // A new transfer may start from idle or straight after a data phase.
  assign can_take = (ph_q != PH_ADDR);
  assign accept   = tick && req_valid && can_take;
  assign phase    = ph_q;

  always_comb begin
    ph_d = ph_q;
    if (tick) begin
      unique case (ph_q)
        PH_ADDR: ph_d = PH_DATA;
        default: ph_d = req_valid ? PH_ADDR : PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_kind <= KIND_MRD;
      lat_addr <= '0;
    end else if (accept) begin
      lat_kind <= req_kind;
      lat_addr <= req_addr;
    end
  end
endmodule

// File: rtl/wbus_addr_decode.sv
module wbus_addr_decode
  import wbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CHIP_AW = 11,
  parameter int LANES   = 2
) (
  input  phase_e             phase,
  input  kind_e              lat_kind,
  input  logic [ADDR_W-1:0]  lat_addr,
  output logic [CHIP_AW-1:0] bus_addr,
  output logic [LANES-1:0]   rom_cs_n,
  output logic [LANES-1:0]   ram_cs_n,
  output logic               mem_req,
  output logic               io_req,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               io_rd,
  output logic               io_wr,
  output logic               dec_err,
  output logic               cpu_drive
);
  localparam int HI_W = ADDR_W - CHIP_AW;

  logic [HI_W-1:0] hi;
  logic in_data, is_io, is_wr, rom_hit, ram_hit, bad, go, rom_sel, ram_sel;

  assign hi      = lat_addr[ADDR_W-1:CHIP_AW];
  assign rom_hit = (hi == HI_W'(0));
  assign ram_hit = (hi == HI_W'(1));
  assign in_data = (phase == PH_DATA);
  assign is_io   = kind_is_io(lat_kind);
  assign is_wr   = kind_is_wr(lat_kind);

  // Full decode: unmapped addresses and writes to read-only space are rejected.
  assign bad = !is_io && (!(rom_hit || ram_hit) || (rom_hit && is_wr));
  assign go  = in_data && !bad;

  assign mem_req   = in_data && !is_io;
  assign io_req    = in_data && is_io;
  assign mem_rd    = go && !is_io && !is_wr;
  assign mem_wr    = go && !is_io && is_wr;
  assign io_rd     = go && is_io && !is_wr;
  assign io_wr     = go && is_io && is_wr;
  assign dec_err   = in_data && bad;
  assign cpu_drive = go && is_wr;

  assign rom_sel = go && !is_io && rom_hit;
  assign ram_sel = go && !is_io && ram_hit;

  assign bus_addr = (phase != PH_IDLE) ? lat_addr[CHIP_AW-1:0] : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rom_cs_n[g] = ~rom_sel;
    assign ram_cs_n[g] = ~ram_sel;
  end
endmodule

// File: rtl/wbus_ctrl.sv
module wbus_ctrl
  import wbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CHIP_AW = 11,
  parameter int LANES   = 2,
  parameter int DIV     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_accept,
  output logic               clk_en,
  output logic               addr_phase,
  output logic               data_phase,
  output logic [CHIP_AW-1:0] bus_addr,
  output logic [LANES-1:0]   rom_cs_n,
  output logic [LANES-1:0]   ram_cs_n,
  output logic               mem_req,
  output logic               io_req,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               io_rd,
  output logic               io_wr,
  output logic               dec_err,
  output logic               cpu_drive
);
  phase_e            phase;
  kind_e             lat_kind;
  logic [ADDR_W-1:0] lat_addr;

  wbus_clk_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (clk_en)
  );

  wbus_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (clk_en),
    .req_valid (req_valid),
    .req_kind  (kind_e'(req_kind)),
    .req_addr  (req_addr),
    .accept    (req_accept),
    .phase     (phase),
    .lat_kind  (lat_kind),
    .lat_addr  (lat_addr)
  );

  wbus_addr_decode #(.ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW), .LANES(LANES)) u_dec (
    .phase     (phase),
    .lat_kind  (lat_kind),
    .lat_addr  (lat_addr),
    .bus_addr  (bus_addr),
    .rom_cs_n  (rom_cs_n),
    .ram_cs_n  (ram_cs_n),
    .mem_req   (mem_req),
    .io_req    (io_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .dec_err   (dec_err),
    .cpu_drive (cpu_drive)
  );

  assign addr_phase = (phase == PH_ADDR);
  assign data_phase = (phase == PH_DATA);
endmodule

// File: rtl/wbus_ctrl_chk.sv
module wbus_ctrl_chk #(
  parameter int CHIP_AW = 11,
  parameter int LANES   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_accept,
  input logic               clk_en,
  input logic               addr_phase,
  input logic               data_phase,
  input logic [CHIP_AW-1:0] bus_addr,
  input logic [LANES-1:0]   rom_cs_n,
  input logic [LANES-1:0]   ram_cs_n,
  input logic               mem_req,
  input logic               io_req,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               io_rd,
  input logic               io_wr,
  input logic               dec_err,
  input logic               cpu_drive
);
  logic rom_on, ram_on, busy;
  assign rom_on = (rom_cs_n != '1);
  assign ram_on = (ram_cs_n != '1);
  assign busy   = addr_phase || data_phase;

  // R1
  en_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> !clk_en);
  // R2
  accept_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (clk_en && req_valid && !addr_phase));
  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_phase && data_phase));
  // R3
  accept_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> addr_phase);
  // R3
  addr_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && clk_en) |=> data_phase);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(req_accept)) |-> $stable(bus_addr));
  // R5
  one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_on, ram_on}));
  // R6
  sel_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_on || ram_on) |-> (data_phase && mem_req));
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (!rom_on && !ram_on && !mem_rd && !mem_wr));
  // R8
  rom_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_on && mem_wr));
  // R9
  strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr || mem_req || io_req) |-> data_phase);
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
  // R10
  bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_drive |-> (data_phase && !mem_rd && !io_rd));
endmodule

bind wbus_ctrl wbus_ctrl_chk #(.CHIP_AW(CHIP_AW), .LANES(LANES)) u_chk (.*);

// File: tb/wbus_ctrl_tb.sv
module wbus_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic        req_accept, clk_en, addr_phase, data_phase;
  logic [10:0] bus_addr;
  logic [1:0]  rom_cs_n, ram_cs_n;
  logic        mem_req, io_req, mem_rd, mem_wr, io_rd, io_wr, dec_err, cpu_drive;

  wbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_accept(req_accept), .clk_en(clk_en),
    .addr_phase(addr_phase), .data_phase(data_phase), .bus_addr(bus_addr),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .mem_req(mem_req), .io_req(io_req),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .dec_err(dec_err), .cpu_drive(cpu_drive)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural reference: divider count, phase (0 idle, 1 address, 2 data), latched request.
  int          m_cnt, m_ph;
  logic [15:0] m_addr;
  logic [1:0]  m_kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ph <= 0; m_addr <= '0; m_kind <= '0;
    end else begin
      m_cnt <= (m_cnt == 2) ? 0 : m_cnt + 1;
      if (m_cnt == 2) begin
        if (m_ph == 1) m_ph <= 2;
        else if (req_valid) begin
          m_ph <= 1; m_addr <= req_addr; m_kind <= req_kind;
        end else m_ph <= 0;
      end
    end
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tg(string t);
    return rst_n ? t : "R11";
  endfunction

  task automatic compare();
    bit data, mem, wr, romh, ramh, err, go;
    string et;
    data = (m_ph == 2);
    mem  = !m_kind[1];
    wr   = m_kind[0];
    romh = (m_addr < 16'd2048);
    ramh = (m_addr >= 16'd2048) && (m_addr < 16'd4096);
    err  = data && mem && (!(romh || ramh) || (romh && wr));
    go   = data && !err;
    et   = (romh && wr) ? "R8" : "R7";
    chk(tg("R1"), "clk_en", 16'(clk_en), 16'(m_cnt == 2));
    chk(tg("R2"), "req_accept", 16'(req_accept), 16'((m_cnt == 2) && req_valid && (m_ph != 1)));
    chk(tg("R3"), "addr_phase", 16'(addr_phase), 16'(m_ph == 1));
    chk(tg("R3"), "data_phase", 16'(data_phase), 16'(data));
    chk(tg("R4"), "bus_addr", 16'(bus_addr), (m_ph != 0) ? {5'd0, m_addr[10:0]} : 16'd0);
    chk(tg("R5"), "rom_cs_n", 16'(rom_cs_n), (go && mem && romh) ? 16'd0 : 16'd3);
    chk(tg("R6"), "ram_cs_n", 16'(ram_cs_n), (go && mem && ramh) ? 16'd0 : 16'd3);
    chk(tg(et), "dec_err", 16'(dec_err), 16'(err));
    chk(tg("R9"), "mem_req", 16'(mem_req), 16'(data && mem));
    chk(tg("R9"), "io_req", 16'(io_req), 16'(data && !mem));
    chk(tg(err ? et : "R9"), "mem_rd", 16'(mem_rd), 16'(go && mem && !wr));
    chk(tg(err ? et : "R9"), "mem_wr", 16'(mem_wr), 16'(go && mem && wr));
    chk(tg("R9"), "io_rd", 16'(io_rd), 16'(go && !mem && !wr));
    chk(tg("R9"), "io_wr", 16'(io_wr), 16'(go && !mem && wr));
    chk(tg("R10"), "cpu_drive", 16'(cpu_drive), 16'(go && wr));
  endtask

  always begin
    @(posedge clk);
    #3;
    if (!done) compare();
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog: got hang expected completion");
      finish_run();
    end
  end

  // Called on a falling edge; returns on the falling edge after the accept.
  task automatic issue(logic [1:0] k, logic [15:0] a);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    while (!req_accept) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
    idle(3);
    // R11 checked by the compare loop while reset is held.
    rst_n = 1'b1;
    idle(4);
    issue(2'b00, 16'd0);         // R5 read low end of read-only region
    idle(8);
    issue(2'b00, 16'd2047);      // R5 top of read-only region
    issue(2'b01, 16'd100);       // R8 write to read-only region
    issue(2'b00, 16'd2048);      // R6 bottom of read-write region
    issue(2'b01, 16'd4095);      // R6 R10 write at top of read-write region
    idle(7);
    issue(2'b00, 16'd4096);      // R7 first unmapped address
    issue(2'b01, 16'hFFFF);      // R7 unmapped write
    issue(2'b10, 16'h1234);      // R9 I/O read
    issue(2'b11, 16'hABCD);      // R9 R10 I/O write
    issue(2'b01, 16'd2500);      // R6 read-write region write
    idle(9);
    // Reset in the middle of a transfer.
    issue(2'b01, 16'd3000);
    idle(1);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    issue(2'b00, 16'd1500);      // R5 after recovery
    idle(10);
    finish_run();
  end
endmodule